// File: doc/BRIEF.md
# Four-Digit Code Lock Controller

This block is the control core of a keypad code lock. It takes one decoded key strobe per cycle: a digit from 0 to 9, a clear key or an enter key. It keeps a four-position entry buffer that drives four BCD display positions. Each position has a flag that marks it as unused, so the display shows a dash there. The block also holds a stored password, a flag that allows the password to be changed, and an unlock output. Keypad scanning and seven-segment encoding sit outside this block.

Short commands are typed as two equal digits followed by enter. 5,5,enter starts a release: the old password is typed, and a correct entry allows the password to be changed. 1,1,enter locks the password again. 9,9,enter starts an unlock attempt. While the password may be changed, typing four digits and then enter in idle stores them as the new password. Any failed comparison raises a one-cycle error pulse.

Top module: `code_lock_ctrl`

## Requirements
- R1: Key codes are 0–9 for digits, 10 for clear and 11 for enter. Display position i (i = 0 is rightmost) is `disp_digit[4i+3:4i]`, and `disp_dash[i]` = 1 means that position shows a dash. One cycle after a digit strobe with fewer than 4 digits held, the new digit is in position 0, every earlier digit has moved up one position, and one more dash flag is cleared.
- R2: A digit strobe with all 4 positions filled changes neither the digits nor the dash flags.
- R3: Clear empties the buffer (all four dash flags set, digits 0), returns `mode_o` to idle (0) and drops `unlock`, all visible one cycle later.
- R4: Enter with exactly the two digits 5,5 in idle sets `mode_o` to release (1) and empties the buffer. In release mode, four digits then enter compares them with the stored password. A match sets `pw_open`, a mismatch pulses `err`. Either way the block returns to idle with an empty buffer.
- R5: In idle with `pw_open` set, four digits then enter stores the displayed digits as the new password. Later unlock attempts compare against that value.
- R6: Enter with exactly the digits 1,1 in idle clears `pw_open`.
- R7: While `pw_open` is clear, the stored password never changes. Four digits then enter in idle only clears the buffer.
- R8: Enter with exactly 9,9 in idle sets `mode_o` to unlock (2). Four digits then enter compares them with the stored password. A match sets `unlock` and a mismatch pulses `err` for exactly one cycle. `unlock` stays set until the next clear or digit strobe.
- R9: Enter in release or unlock mode with fewer than 4 digits held, or enter in idle with an entry that matches no command and no store, empties the buffer and leaves the block in idle. It changes neither the password nor `pw_open`, and it raises no error.
- R10: Strobes with key codes 12 to 15 have no effect on any output.
- R11: Reset empties the buffer, sets the password to 0000, clears `pw_open`, `unlock` and `err`, and puts `mode_o` in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | One-cycle strobe of a decoded key |
| key_code | input | 4 | Key value: 0–9 digit, 10 clear, 11 enter |
| disp_digit | output | 16 | Four BCD display digits, position 0 in bits 3:0 |
| disp_dash | output | 4 | Per position: show a dash instead of the digit |
| unlock | output | 1 | Lock open after a matching unlock attempt |
| pw_open | output | 1 | Password may be changed |
| err | output | 1 | One-cycle pulse on a failed comparison |
| mode_o | output | 2 | 0 idle, 1 release, 2 unlock |

## Verification
An enter strobe does two things in the same cycle: it ends a comparison and it clears the buffer. So the compare result (`unlock`, `pw_open` or `err`) appears in the same cycle that the display falls back to four dashes and the mode returns to idle. The bench types full sequences and, after each enter, checks every output in that one sampled cycle: the comparison outcome, the dashes and the mode together. It also confirms that the error pulse is gone one cycle later and that a held unlock is dropped by the very next digit, whose shift into the buffer falls in that same cycle.

// File: rtl/lock_pkg.sv
package lock_pkg;
    localparam int DW = 4;
    localparam logic [3:0] KEY_CLEAR = 4'd10;
    localparam logic [3:0] KEY_ENTER = 4'd11;
    localparam logic [3:0] CMD_RELEASE = 4'd5;
    localparam logic [3:0] CMD_LOCK    = 4'd1;
    localparam logic [3:0] CMD_UNLOCK  = 4'd9;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_RELEASE = 2'd1,
        MODE_UNLOCK  = 2'd2
    } mode_e;
endpackage

// File: rtl/lock_entry_buf.sv
module lock_entry_buf #(
    parameter int N_DIG = 4,
    parameter int DW    = 4,
    localparam int CW   = $clog2(N_DIG + 1),
    localparam int BW   = N_DIG * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          clr,
    input  logic [DW-1:0] din,
    output logic [BW-1:0] digits,
    output logic [CW-1:0] count,
    output logic [N_DIG-1:0] dash
);
    typedef struct packed {
        logic [BW-1:0] dig;
        logic [CW-1:0] cnt;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d = '0;
        end else if (push && (buf_q.cnt < CW'(N_DIG))) begin
            buf_d.dig = (buf_q.dig << DW) | BW'(din);
            buf_d.cnt = buf_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign digits = buf_q.dig;
    assign count  = buf_q.cnt;

    for (genvar i = 0; i < N_DIG; i++) begin : g_dash
        assign dash[i] = (buf_q.cnt <= CW'(i));
    end
endmodule

// File: rtl/lock_cmd_dec.sv
module lock_cmd_dec
    import lock_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic [2*DW-1:0] pair,
    input  logic [CW-1:0]   count,
    output logic            is_release,
    output logic            is_lock,
    output logic            is_unlock
);
    logic two;
    assign two        = (count == CW'(2));
    assign is_release = two && (pair == {CMD_RELEASE, CMD_RELEASE});
    assign is_lock    = two && (pair == {CMD_LOCK, CMD_LOCK});
    assign is_unlock  = two && (pair == {CMD_UNLOCK, CMD_UNLOCK});
endmodule

// File: rtl/lock_pw_cmp.sv
module lock_pw_cmp #(
    parameter int N_DIG = 4,
    parameter int DW    = 4
) (
    input  logic [N_DIG*DW-1:0] entry,
    input  logic [N_DIG*DW-1:0] stored,
    output logic                match
);
    logic [N_DIG-1:0] eq;
    for (genvar i = 0; i < N_DIG; i++) begin : g_eq
        assign eq[i] = (entry[i*DW +: DW] == stored[i*DW +: DW]);
    end
    assign match = &eq;
endmodule

// File: rtl/code_lock_ctrl.sv
module code_lock_ctrl
    import lock_pkg::*;
#(
    parameter int N_DIG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_valid,
    input  logic [3:0]          key_code,
    output logic [N_DIG*DW-1:0] disp_digit,
    output logic [N_DIG-1:0]    disp_dash,
    output logic                unlock,
    output logic                pw_open,
    output logic                err,
    output logic [1:0]          mode_o
);
    localparam int CW = $clog2(N_DIG + 1);
    localparam int BW = N_DIG * DW;

    typedef struct packed {
        mode_e         mode;
        logic [BW-1:0] pw;
        logic          open;
        logic          unl;
        logic          err;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic          k_digit, k_clear, k_enter;
    logic [BW-1:0] entry;
    logic [CW-1:0] count;
    logic          full, is_rel, is_lock, is_unl, match;
    logic [BW-1:0] pw_cur;

    assign k_digit = key_valid && (key_code <= 4'd9);
    assign k_clear = key_valid && (key_code == KEY_CLEAR);
    assign k_enter = key_valid && (key_code == KEY_ENTER);

    lock_entry_buf #(.N_DIG(N_DIG), .DW(DW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (k_digit),
        .clr    (k_clear || k_enter),
        .din    (key_code),
        .digits (entry),
        .count  (count),
        .dash   (disp_dash)
    );

    lock_cmd_dec #(.CW(CW)) u_dec (
        .pair       (entry[2*DW-1:0]),
        .count      (count),
        .is_release (is_rel),
        .is_lock    (is_lock),
        .is_unlock  (is_unl)
    );

    lock_pw_cmp #(.N_DIG(N_DIG), .DW(DW)) u_cmp (
        .entry  (entry),
        .stored (st_q.pw),
        .match  (match)
    );

    assign full = (count == CW'(N_DIG));

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (k_clear) begin
            st_d.mode = MODE_IDLE;
            st_d.unl  = 1'b0;
        end else if (k_digit) begin
            st_d.unl = 1'b0;
        end else if (k_enter) begin
            st_d.mode = MODE_IDLE;
            case (st_q.mode)
                MODE_IDLE: begin
                    if (is_rel)                  st_d.mode = MODE_RELEASE;
                    else if (is_unl)             st_d.mode = MODE_UNLOCK;
                    else if (is_lock)            st_d.open = 1'b0;
                    else if (full && st_q.open)  st_d.pw   = entry;
                end
                MODE_RELEASE: begin
                    if (full) begin
                        if (match) st_d.open = 1'b1;
                        else       st_d.err  = 1'b1;
                    end
                end
                MODE_UNLOCK: begin
                    if (full) begin
                        if (match) st_d.unl = 1'b1;
                        else       st_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_IDLE;
            st_q.pw   <= '0;
            st_q.open <= 1'b0;
            st_q.unl  <= 1'b0;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_digit = entry;
    assign unlock     = st_q.unl;
    assign pw_open    = st_q.open;
    assign err        = st_q.err;
    assign mode_o     = st_q.mode;
    assign pw_cur     = st_q.pw;
endmodule

// File: rtl/code_lock_ctrl_chk.sv
module code_lock_ctrl_chk
    import lock_pkg::*;
#(
    parameter int N_DIG = 4,
    localparam int W = N_DIG * DW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_valid,
    input logic [3:0]       key_code,
    input logic [W-1:0]     disp_digit,
    input logic [N_DIG-1:0] disp_dash,
    input logic             unlock,
    input logic             pw_open,
    input logic             err,
    input logic [1:0]       mode_o,
    input logic [W-1:0]     pw_cur
);
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_code <= 4'd9 && disp_dash[N_DIG-1])
        |=> (disp_digit[DW-1:0] == $past(key_code))
            && (disp_digit[W-1:DW] == $past(disp_digit[W-DW-1:0]))); // R1

    AST_DASH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        ((N_DIG'(disp_dash << 1)) & ~disp_dash) == '0); // R1

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_code <= 4'd9 && disp_dash == '0)
        |=> $stable(disp_digit) && (disp_dash == '0)); // R2

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_code == KEY_CLEAR)
        |=> (&disp_dash) && !unlock && (mode_o == MODE_IDLE)); // R3

    AST_OPEN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pw_open) |-> $past(key_valid && key_code == KEY_ENTER
                                 && mode_o == MODE_RELEASE)); // R4

    AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pw_open) |-> $past(key_valid && key_code == KEY_ENTER
                                 && mode_o == MODE_IDLE)); // R6

    AST_PW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pw_open |=> $stable(pw_cur)); // R7

    AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> $past(key_valid && key_code == KEY_ENTER
                                && mode_o == MODE_UNLOCK)); // R8

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R8

    AST_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_code > 4'd11)
        |=> $stable(disp_digit) && $stable(disp_dash) && $stable(unlock)
            && $stable(mode_o) && $stable(pw_open)); // R10
endmodule

bind code_lock_ctrl code_lock_ctrl_chk #(.N_DIG(N_DIG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_valid  (key_valid),
    .key_code   (key_code),
    .disp_digit (disp_digit),
    .disp_dash  (disp_dash),
    .unlock     (unlock),
    .pw_open    (pw_open),
    .err        (err),
    .mode_o     (mode_o),
    .pw_cur     (pw_cur)
);

// File: tb/test_code_lock_ctrl.sv
module test_code_lock_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [3:0]  key_code = 4'd0;
    logic [15:0] disp_digit;
    logic [3:0]  disp_dash;
    logic        unlock, pw_open, err;
    logic [1:0]  mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    code_lock_ctrl i_code_lock_ctrl (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .disp_digit(disp_digit), .disp_dash(disp_dash), .unlock(unlock),
        .pw_open(pw_open), .err(err), .mode_o(mode_o)
    );

    // key, digits, dash, {unlock,pw_open,err}, mode
    typedef struct packed {
        logic [3:0]  k;
        logic [15:0] dig;
        logic [3:0]  dash;
        logic [2:0]  fl;
        logic [1:0]  md;
    } vec_t;

    localparam int NV = 59;
    localparam vec_t VEC [NV] = '{
        {4'h1,16'h0001,4'hE,3'b000,2'd0},  // R1
        {4'h2,16'h0012,4'hC,3'b000,2'd0},  // R1
        {4'h3,16'h0123,4'h8,3'b000,2'd0},  // R1
        {4'h4,16'h1234,4'h0,3'b000,2'd0},  // R1
        {4'h5,16'h1234,4'h0,3'b000,2'd0},  // R2 overflow digit
        {4'hA,16'h0000,4'hF,3'b000,2'd0},  // R3
        {4'h9,16'h0009,4'hE,3'b000,2'd0},
        {4'h9,16'h0099,4'hC,3'b000,2'd0},
        {4'hB,16'h0000,4'hF,3'b000,2'd2},  // R8 enter unlock mode
        {4'h0,16'h0000,4'hE,3'b000,2'd2},
        {4'h0,16'h0000,4'hC,3'b000,2'd2},
        {4'h0,16'h0000,4'h8,3'b000,2'd2},
        {4'h0,16'h0000,4'h0,3'b000,2'd2},
        {4'hB,16'h0000,4'hF,3'b100,2'd0},  // R8 default 0000 matches
        {4'h7,16'h0007,4'hE,3'b000,2'd0},  // R8 digit drops unlock
        {4'hA,16'h0000,4'hF,3'b000,2'd0},  // R3
        {4'h5,16'h0005,4'hE,3'b000,2'd0},
        {4'h5,16'h0055,4'hC,3'b000,2'd0},
        {4'hB,16'h0000,4'hF,3'b000,2'd1},  // R4 release mode
        {4'h1,16'h0001,4'hE,3'b000,2'd1},
        {4'h2,16'h0012,4'hC,3'b000,2'd1},
        {4'h3,16'h0123,4'h8,3'b000,2'd1},
        {4'h4,16'h1234,4'h0,3'b000,2'd1},
        {4'hB,16'h0000,4'hF,3'b001,2'd0},  // R4 wrong old password
        {4'h5,16'h0005,4'hE,3'b000,2'd0},
        {4'h5,16'h0055,4'hC,3'b000,2'd0},
        {4'hB,16'h0000,4'hF,3'b000,2'd1},  // R4
        {4'h0,16'h0000,4'hE,3'b000,2'd1},
        {4'h0,16'h0000,4'hC,3'b000,2'd1},
        {4'h0,16'h0000,4'h8,3'b000,2'd1},
        {4'h0,16'h0000,4'h0,3'b000,2'd1},
        {4'hB,16'h0000,4'hF,3'b010,2'd0},  // R4 release succeeds
        {4'h2,16'h0002,4'hE,3'b010,2'd0},
        {4'h3,16'h0023,4'hC,3'b010,2'd0},
        {4'h4,16'h0234,4'h8,3'b010,2'd0},
        {4'h5,16'h2345,4'h0,3'b010,2'd0},
        {4'hB,16'h0000,4'hF,3'b010,2'd0},  // R5 store 2345
        {4'h1,16'h0001,4'hE,3'b010,2'd0},
        {4'h1,16'h0011,4'hC,3'b010,2'd0},
        {4'hB,16'h0000,4'hF,3'b000,2'd0},  // R6 lock
        {4'h9,16'h0009,4'hE,3'b000,2'd0},
        {4'h9,16'h0099,4'hC,3'b000,2'd0},
        {4'hB,16'h0000,4'hF,3'b000,2'd2},
        {4'h2,16'h0002,4'hE,3'b000,2'd2},
        {4'h3,16'h0023,4'hC,3'b000,2'd2},
        {4'h4,16'h0234,4'h8,3'b000,2'd2},
        {4'h5,16'h2345,4'h0,3'b000,2'd2},
        {4'hB,16'h0000,4'hF,3'b100,2'd0},  // R5 new password opens
        {4'h9,16'h0009,4'hE,3'b000,2'd0},
        {4'h9,16'h0099,4'hC,3'b000,2'd0},
        {4'hB,16'h0000,4'hF,3'b000,2'd2},
        {4'h0,16'h0000,4'hE,3'b000,2'd2},
        {4'h0,16'h0000,4'hC,3'b000,2'd2},
        {4'h0,16'h0000,4'h8,3'b000,2'd2},
        {4'h0,16'h0000,4'h0,3'b000,2'd2},
        {4'hB,16'h0000,4'hF,3'b001,2'd0},  // R8 old password fails
        {4'h4,16'h0004,4'hE,3'b000,2'd0},
        {4'h4,16'h0044,4'hC,3'b000,2'd0},
        {4'hB,16'h0000,4'hF,3'b000,2'd0}   // R9 unknown command
    };

    task automatic press(input logic [3:0] k);
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = k;
        @(negedge clk);
        key_valid = 1'b0;
        key_code  = 4'd0;
    endtask

    task automatic seq4(input logic [3:0] a, b, c, d);
        press(a); press(b); press(c); press(d);
    endtask

    task automatic chk(input string req, input logic [15:0] dg, input logic [3:0] ds,
                       input logic [2:0] fl, input logic [1:0] md);
        logic [28:0] act, exp;
        act = {4'h0, disp_digit, disp_dash, unlock, pw_open, err, mode_o};
        exp = {4'h0, dg, ds, fl, md};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual dig=%h dash=%b unl/open/err=%b%b%b mode=%0d expected dig=%h dash=%b unl/open/err=%b mode=%0d",
                     req, disp_digit, disp_dash, unlock, pw_open, err, mode_o, dg, ds, fl, md);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset state", 16'h0000, 4'hF, 3'b000, 2'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            press(VEC[i].k);
            chk($sformatf("table step %0d", i), VEC[i].dig, VEC[i].dash, VEC[i].fl, VEC[i].md);
        end

        // R7: locked, store attempt ignored; 2345 still opens
        seq4(4'h6, 4'h7, 4'h8, 4'h9); press(4'hB);
        chk("R7 store while locked", 16'h0000, 4'hF, 3'b000, 2'd0);
        press(4'h9); press(4'h9); press(4'hB);
        seq4(4'h2, 4'h3, 4'h4, 4'h5); press(4'hB);
        chk("R7 password unchanged", 16'h0000, 4'hF, 3'b100, 2'd0);

        // R10: codes 12..15 have no effect
        press(4'hC);
        chk("R10 code 12", 16'h0000, 4'hF, 3'b100, 2'd0);
        press(4'h1); press(4'hF);
        chk("R10 code 15", 16'h0001, 4'hE, 3'b000, 2'd0);
        press(4'hA);
        chk("R3 clear", 16'h0000, 4'hF, 3'b000, 2'd0);

        // R9: short entries in a mode
        press(4'h9); press(4'h9); press(4'hB); press(4'h1); press(4'hB);
        chk("R9 short unlock entry", 16'h0000, 4'hF, 3'b000, 2'd0);
        press(4'h5); press(4'h5); press(4'hB); press(4'hB);
        chk("R9 empty release entry", 16'h0000, 4'hF, 3'b000, 2'd0);

        // R8: error is a single-cycle pulse
        press(4'h9); press(4'h9); press(4'hB);
        seq4(4'h0, 4'h0, 4'h0, 4'h0); press(4'hB);
        chk("R8 error raised", 16'h0000, 4'hF, 3'b001, 2'd0);
        @(negedge clk);
        chk("R8 error one cycle", 16'h0000, 4'hF, 3'b000, 2'd0);

        // R11: reset mid-entry restores 0000
        press(4'h1); press(4'h2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 reset clears", 16'h0000, 4'hF, 3'b000, 2'd0);
        rst_n = 1'b1;
        press(4'h9); press(4'h9); press(4'hB);
        seq4(4'h0, 4'h0, 4'h0, 4'h0); press(4'hB);
        chk("R11 default password", 16'h0000, 4'hF, 3'b100, 2'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule